// File: doc/BRIEF.md
# Synchronous Exception Request Unit

This unit sits beside the decode stage of a processor and turns faults and trap opcodes found there into level-3 (nonmaskable) exception requests. It watches three sources: a hardware stack that has overflowed or underflowed, an opcode that decodes as illegal, and a software-interrupt opcode. When one of them is flagged, the unit produces, one clock later, a one-hot request, the program address of the handler, and the program address that the interrupt sequencer must push as the return point.

The return address depends on where the faulting word was found. An illegal word fetched from one of the two words of an interrupt vector returns to the flow that the interrupt broke into, supplied on a separate input. An illegal word that follows a repeat instruction is run as a repeated no-op. Its return point then lies two words past it, and the word already fetched behind it must be dropped without being decoded. A software interrupt returns to the next word and also asks for the interrupt mask to be raised to level 3. Stack memory, full opcode decoding and arbitration against peripheral interrupts belong to other blocks.

Handler addresses come from a parameter table, one entry per source. The cycle that follows a request is taken up by the vector insertion, so any flags present in that cycle are ignored.

Top module: `sync_trap_unit`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, `trap_req_o` is 0, `trap_vec_o` is 0, `push_pc_o` is 0, `mask_l3_o` is 0 and `squash_next_o` is 0.
- R2: A stack overflow or underflow flag sampled at an edge gives `trap_req_o` = 3'b001 after that edge, with `trap_vec_o` = 0x0002 and `push_pc_o` = `fetch_pc_i`.
- R3: An illegal-opcode flag sampled at an edge, with neither `vec_slot_i` nor `rep_active_i` set, gives `trap_req_o` = 3'b010 after that edge, with `trap_vec_o` = 0x0004 and `push_pc_o` = `fetch_pc_i`.
- R4: An illegal opcode sampled with `vec_slot_i` set gives `push_pc_o` = `resume_pc_i`, whether or not `rep_active_i` is set. `squash_next_o` stays 0.
- R5: An illegal opcode sampled with `rep_active_i` set and `vec_slot_i` clear gives `push_pc_o` = `fetch_pc_i` + 2, modulo 2^16, and sets `squash_next_o` in the same cycle as the request.
- R6: A software-interrupt flag gives `trap_req_o` = 3'b100 after the edge, with `trap_vec_o` = 0x0006, `push_pc_o` = `fetch_pc_i` + 1 and `mask_l3_o` = 1. `mask_l3_o` is 1 only together with this request.
- R7: When several sources are flagged at the same edge, the stack error wins over the illegal opcode, and the illegal opcode wins over the software interrupt. Only the winner's bit, vector and return address appear.
- R8: `trap_req_o` has at most one bit set and is never nonzero in two consecutive cycles. Source flags sampled at the edge that follows a request are ignored.
- R9: With no source flagged, or with flags ignored under R8, all outputs are 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stk_ovf_i | input | 1 | Hardware stack overflow this cycle |
| stk_unf_i | input | 1 | Hardware stack underflow this cycle |
| ill_op_i | input | 1 | Decoded word is an illegal opcode |
| swi_op_i | input | 1 | Decoded word is a software-interrupt opcode |
| fetch_pc_i | input | 16 | Program address of the word being decoded |
| resume_pc_i | input | 16 | Return address of the flow that an interrupt broke into |
| vec_slot_i | input | 1 | Decoded word was fetched from an interrupt vector slot |
| rep_active_i | input | 1 | Decoded word is the target of a repeat instruction |
| trap_req_o | output | 3 | One-hot request: bit 0 stack error, bit 1 illegal, bit 2 software interrupt |
| trap_vec_o | output | 16 | Handler address for the request |
| push_pc_o | output | 16 | Return address to be stacked |
| mask_l3_o | output | 1 | Raise the interrupt mask to level 3 |
| squash_next_o | output | 1 | Discard the already-fetched word behind the illegal one |

## Verification
A wrong priority or a stale hold-off flag shows at the ports one cycle after the flags are sampled. It appears as the wrong one-hot bit, as a missing request, or as requests on back-to-back cycles. A wrong return-address selection shows in that same cycle as a `push_pc_o` that is off by 0, 1 or 2 words, or that equals the resume input where the fetch address belongs. Flags are mixed at random with every context combination, so a single bad case in the return-address select shows up within a few dozen cycles.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NSRC = 3;
  typedef enum logic [1:0] {
    SRC_STK = 2'd0,
    SRC_ILL = 2'd1,
    SRC_SWI = 2'd2
  } trap_src_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int N      = 3,
  parameter int ADDR_W = 16,
  parameter logic [N-1:0][ADDR_W-1:0] VEC_TAB = '0
) (
  input  logic [N-1:0]      raw_i,
  output logic [N-1:0]      grant_o,
  output logic [ADDR_W-1:0] vec_o
);
  // Lowest index wins: isolate the lowest set bit.
  assign grant_o = raw_i & (~raw_i + N'(1));

  logic [N:0][ADDR_W-1:0] acc;
  assign acc[0] = '0;
  for (genvar g = 0; g < N; g++) begin : g_vec
    assign acc[g+1] = acc[g] | (grant_o[g] ? VEC_TAB[g] : '0);
  end
  assign vec_o = acc[N];
endmodule

// File: rtl/trap_ret_sel.sv
module trap_ret_sel
  import trap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [NSRC-1:0]   grant_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic [ADDR_W-1:0] resume_pc_i,
  input  logic              vec_slot_i,
  input  logic              rep_active_i,
  output logic [ADDR_W-1:0] ret_pc_o,
  output logic              squash_o,
  output logic              mask_o
);
  always_comb begin
    ret_pc_o = '0;
    squash_o = 1'b0;
    mask_o   = 1'b0;
    if (grant_i[SRC_STK]) begin
      ret_pc_o = fetch_pc_i;
    end else if (grant_i[SRC_ILL]) begin
      if (vec_slot_i) begin
        ret_pc_o = resume_pc_i;
      end else if (rep_active_i) begin
        ret_pc_o = fetch_pc_i + ADDR_W'(2);
        squash_o = 1'b1;
      end else begin
        ret_pc_o = fetch_pc_i;
      end
    end else if (grant_i[SRC_SWI]) begin
      ret_pc_o = fetch_pc_i + ADDR_W'(1);
      mask_o   = 1'b1;
    end
  end
endmodule

// File: rtl/sync_trap_unit.sv
module sync_trap_unit
  import trap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [NSRC-1:0][ADDR_W-1:0] VEC_TAB = {16'h0006, 16'h0004, 16'h0002}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stk_ovf_i,
  input  logic              stk_unf_i,
  input  logic              ill_op_i,
  input  logic              swi_op_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic [ADDR_W-1:0] resume_pc_i,
  input  logic              vec_slot_i,
  input  logic              rep_active_i,
  output logic [NSRC-1:0]   trap_req_o,
  output logic [ADDR_W-1:0] trap_vec_o,
  output logic [ADDR_W-1:0] push_pc_o,
  output logic              mask_l3_o,
  output logic              squash_next_o
);
  logic [NSRC-1:0]   raw, grant;
  logic [ADDR_W-1:0] vec_c, ret_c;
  logic              squash_c, mask_c;
  logic              holdoff;

  // Cycle after a request is spent inserting the vector.
  assign holdoff = |trap_req_o;

  always_comb begin
    raw          = '0;
    raw[SRC_STK] = stk_ovf_i | stk_unf_i;
    raw[SRC_ILL] = ill_op_i;
    raw[SRC_SWI] = swi_op_i;
    if (holdoff) raw = '0;
  end

  trap_arbiter #(.N(NSRC), .ADDR_W(ADDR_W), .VEC_TAB(VEC_TAB)) u_arb (
    .raw_i   (raw),
    .grant_o (grant),
    .vec_o   (vec_c)
  );

  trap_ret_sel #(.ADDR_W(ADDR_W)) u_ret (
    .grant_i      (grant),
    .fetch_pc_i   (fetch_pc_i),
    .resume_pc_i  (resume_pc_i),
    .vec_slot_i   (vec_slot_i),
    .rep_active_i (rep_active_i),
    .ret_pc_o     (ret_c),
    .squash_o     (squash_c),
    .mask_o       (mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req_o    <= '0;
      trap_vec_o    <= '0;
      push_pc_o     <= '0;
      mask_l3_o     <= 1'b0;
      squash_next_o <= 1'b0;
    end else begin
      trap_req_o    <= grant;
      trap_vec_o    <= vec_c;
      push_pc_o     <= ret_c;
      mask_l3_o     <= mask_c;
      squash_next_o <= squash_c;
    end
  end
endmodule

// File: rtl/sync_trap_unit_chk.sv
module sync_trap_unit_chk #(
  parameter int ADDR_W = 16,
  parameter logic [2:0][ADDR_W-1:0] VEC_TAB = {16'h0006, 16'h0004, 16'h0002}
) (
  input logic              clk,
  input logic              rst,
  input logic              stk_ovf_i,
  input logic              stk_unf_i,
  input logic              ill_op_i,
  input logic              swi_op_i,
  input logic [2:0]        trap_req_o,
  input logic [ADDR_W-1:0] trap_vec_o,
  input logic              mask_l3_o,
  input logic              squash_next_o
);
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(trap_req_o)); // R8
  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (rst) (|trap_req_o) |=> (trap_req_o == 3'b000)); // R8
  AST_STK_WINS: assert property (@(posedge clk) disable iff (rst) ((stk_ovf_i || stk_unf_i) && trap_req_o == 3'b000) |=> (trap_req_o == 3'b001)); // R7
  AST_ILL_OVER_SWI: assert property (@(posedge clk) disable iff (rst) (ill_op_i && swi_op_i && !stk_ovf_i && !stk_unf_i && trap_req_o == 3'b000) |=> (trap_req_o == 3'b010)); // R7
  AST_STK_VECTOR: assert property (@(posedge clk) disable iff (rst) trap_req_o[0] |-> (trap_vec_o == VEC_TAB[0])); // R2
  AST_MASK_ONLY_SWI: assert property (@(posedge clk) disable iff (rst) mask_l3_o |-> trap_req_o[2]); // R6
  AST_SQUASH_ONLY_ILL: assert property (@(posedge clk) disable iff (rst) squash_next_o |-> trap_req_o[1]); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (!stk_ovf_i && !stk_unf_i && !ill_op_i && !swi_op_i) |=> (trap_req_o == 3'b000 && !mask_l3_o && !squash_next_o)); // R9
endmodule

bind sync_trap_unit sync_trap_unit_chk #(.ADDR_W(ADDR_W), .VEC_TAB(VEC_TAB)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .stk_ovf_i     (stk_ovf_i),
  .stk_unf_i     (stk_unf_i),
  .ill_op_i      (ill_op_i),
  .swi_op_i      (swi_op_i),
  .trap_req_o    (trap_req_o),
  .trap_vec_o    (trap_vec_o),
  .mask_l3_o     (mask_l3_o),
  .squash_next_o (squash_next_o)
);

// File: tb/sim_sync_trap_unit.sv
module sim_sync_trap_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stk_ovf = 0, stk_unf = 0, ill = 0, swi = 0, vslot = 0, rep = 0;
  logic [15:0] fpc = '0, rpc = '0;
  logic [2:0]  req;
  logic [15:0] vec, ppc;
  logic        mask, squash;

  int checks = 0;
  int errors = 0;
  logic model_busy = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  sync_trap_unit u0 (
    .clk(clk), .rst(rst),
    .stk_ovf_i(stk_ovf), .stk_unf_i(stk_unf), .ill_op_i(ill), .swi_op_i(swi),
    .fetch_pc_i(fpc), .resume_pc_i(rpc), .vec_slot_i(vslot), .rep_active_i(rep),
    .trap_req_o(req), .trap_vec_o(vec), .push_pc_o(ppc),
    .mask_l3_o(mask), .squash_next_o(squash)
  );

  // Expected outputs packed as {req, vec, ppc, mask, squash}.
  function automatic logic [36:0] expect_out(input logic busy);
    logic [2:0]  r = 3'b000;
    logic [15:0] v = 16'h0;
    logic [15:0] p = 16'h0;
    logic        m = 1'b0;
    logic        s = 1'b0;
    if (!busy) begin
      if (stk_ovf || stk_unf) begin
        r = 3'b001; v = 16'h0002; p = fpc;
      end else if (ill) begin
        r = 3'b010; v = 16'h0004;
        if (vslot) p = rpc;
        else if (rep) begin p = fpc + 16'd2; s = 1'b1; end
        else p = fpc;
      end else if (swi) begin
        r = 3'b100; v = 16'h0006; p = fpc + 16'd1; m = 1'b1;
      end
    end
    return {r, v, p, m, s};
  endfunction

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s req/vec/pc/mask/squash actual %h_%h_%h_%b_%b expected %h_%h_%h_%b_%b",
               tag, act[36:34], act[33:18], act[17:2], act[1], act[0],
               exp[36:34], exp[33:18], exp[17:2], exp[1], exp[0]);
    end
  endtask

  function automatic string tag_for(input logic [36:0] e);
    if (e[36:34] == 3'b001) return "R2/R7";
    if (e[36:34] == 3'b010) return vslot ? "R4" : (rep ? "R5" : "R3");
    if (e[36:34] == 3'b100) return "R6";
    return model_busy ? "R8" : "R9";
  endfunction

  // Inputs are set at the negedge; compare after the following posedge.
  task automatic step(input logic so, su, il, sw, vs, rp, input logic [15:0] f, r);
    logic [36:0] e;
    string t;
    @(negedge clk);
    stk_ovf = so; stk_unf = su; ill = il; swi = sw; vslot = vs; rep = rp; fpc = f; rpc = r;
    e = expect_out(model_busy);
    t = tag_for(e);
    @(posedge clk); #1;
    check(t, {req, vec, ppc, mask, squash}, e);
    model_busy = |e[36:34];
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 16'h0, 16'h0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state, flags held high during reset
    @(negedge clk);
    stk_ovf = 1; ill = 1; swi = 1; fpc = 16'h1234;
    repeat (2) @(posedge clk);
    #1 check("R1", {req, vec, ppc, mask, squash}, 37'h0);
    @(negedge clk);
    rst = 0; stk_ovf = 0; ill = 0; swi = 0;
    @(posedge clk); #1 check("R1", {req, vec, ppc, mask, squash}, 37'h0);

    // Directed corner cases
    step(1, 0, 0, 0, 0, 0, 16'h0100, 16'h0); idle();                 // R2 overflow
    step(0, 1, 0, 0, 0, 0, 16'h0200, 16'h0); idle();                 // R2 underflow
    step(0, 0, 1, 0, 0, 0, 16'h0300, 16'h0777); idle();              // R3
    step(0, 0, 1, 0, 1, 0, 16'h0003, 16'h0400); idle();              // R4
    step(0, 0, 1, 0, 1, 1, 16'h0005, 16'h0401); idle();              // R4 over repeat
    step(0, 0, 1, 0, 0, 1, 16'h0500, 16'h0); idle();                 // R5
    step(0, 0, 1, 0, 0, 1, 16'hFFFF, 16'h0); idle();                 // R5 wrap
    step(0, 0, 0, 1, 0, 0, 16'h0600, 16'h0); idle();                 // R6
    step(0, 0, 0, 1, 0, 0, 16'hFFFF, 16'h0); idle();                 // R6 wrap
    step(1, 1, 1, 1, 1, 1, 16'h0700, 16'h0800); idle();              // R7 all
    step(0, 0, 1, 1, 0, 1, 16'h0900, 16'h0); idle();                 // R7 ill over swi
    step(0, 0, 0, 1, 0, 0, 16'h0A00, 16'h0);                         // R8 request
    step(1, 0, 1, 0, 0, 0, 16'h0A01, 16'h0);                         // R8 ignored
    step(0, 0, 1, 0, 0, 0, 16'h0A02, 16'h0);                         // accepted again
    idle(); idle();                                                  // R9

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
           16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule